// File: doc/BRIEF.md
# Display clock frequency change sequencer

This block moves the display core clock to a new rate given in kHz. A single-cycle request starts a fixed sequence. The block first tells the power controller that a change is coming. It then switches the display PLL off and waits for it to unlock, but only where that step is needed. Next it loads the new feedback ratio, turns the PLL back on and waits for lock. It then writes a clock control word that holds the post-divider code, a precharge enable and the rate as a fixed-point value. Last, it reports the new rate to the power controller.

Six rates are accepted. The 19.2 MHz rate is a bypass rate that leaves the PLL switched off. A request for any other value is refused at once, and no state changes. A failed mailbox reply or a PLL wait that runs past its limit ends the sequence with an error and a cause code. In every error case the recorded rate keeps its old value.

Top module: `dclk_rate_seq`

## Requirements
- R1: Supported rates and PLL ratios (19.2 MHz units). 144000, 288000, 384000 and 576000 kHz use ratio 60. 624000 kHz uses ratio 65. After a successful change to any of these, pll_en is 1. After a successful change to 19200 kHz, pll_en is 0.
- R2: The post-divider code sits in ctl_word[23:22]. The codes are 0 for divide-by-1 (576000 and 624000 kHz), 1 for divide-by-1.5 (384000), 2 for divide-by-2 (288000) and 3 for divide-by-4 (144000).
- R3: A request for an unsupported rate pulses err with err_cause 0 on the cycle after the request. It makes no mailbox transaction and leaves pll_en, pll_ratio, ctl_word and cur_khz unchanged.
- R4: Every accepted request starts with a mailbox transaction whose data is 0x80000000. Every mailbox transaction uses command 0x17. An error reply to this first transaction pulses err with err_cause 1 and leaves pll_en, ctl_word and cur_khz unchanged.
- R5: ctl_word[10:0] holds (rate − 1000) / 500. The rate read back from the field is field × 500 + 1000 kHz.
- R6: pll_en falls during a change only when the PLL was on and one of these holds: the target is 19200, the target is 624000, or the rate decoded from ctl_word[10:0] is 624000.
- R7: The wait for unlock and the wait for lock each end after LOCK_LIMIT_US pulses of us_tick. When a wait ends this way, err pulses with err_cause 2 and cur_khz stays unchanged.
- R8: ctl_word[16] is 1 when the rate written is 500000 kHz or more, and 0 when it is lower.
- R9: The final mailbox transaction carries ceil(rate / 25000). When it succeeds, done pulses and cur_khz becomes the target. When it fails, err pulses with err_cause 1 instead. done and err never pulse together.
- R10: mbox_req stays high with stable data until mbox_ack is seen. It drops on the next cycle.
- R11: After reset: cur_khz is 19200, pll_en is 0, ctl_word is 0, and mbox_req, done, err and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle change request, taken when idle |
| req_khz | input | 32 | Target rate in kHz |
| busy | output | 1 | A sequence is in progress |
| mbox_req | output | 1 | Mailbox request to the power controller |
| mbox_cmd | output | 8 | Mailbox command, 0x17 |
| mbox_data | output | 32 | Mailbox data word |
| mbox_ack | input | 1 | Mailbox response strobe |
| mbox_err | input | 1 | Mailbox response is a failure, valid with mbox_ack |
| us_tick | input | 1 | One pulse per microsecond |
| pll_en | output | 1 | PLL enable |
| pll_ratio | output | 8 | PLL feedback ratio |
| pll_lock | input | 1 | PLL lock status |
| ctl_word | output | 32 | Clock control word (divider, precharge, fixed-point rate) |
| cur_khz | output | 32 | Last rate applied successfully |
| done | output | 1 | Pulse: change completed |
| err | output | 1 | Pulse: change aborted |
| err_cause | output | 2 | 0 unsupported rate, 1 mailbox failure, 2 PLL timeout |

## Verification
A wrong rate-map entry shows up when that change finishes: pll_ratio, or ctl_word[23:22] or [16], differs from the table. A stale fixed-point field is more subtle. It only shows one request later, as a PLL toggle that should not happen or a missing one, seen on pll_en during that sequence. A corrupted mailbox word, or a request that is not held, is visible on mbox_data and mbox_req within the transaction. A sequencer that runs past an error shows as a changed cur_khz or ctl_word on the cycle the err pulse appears.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

  localparam int unsigned RATIO_W     = 8;
  localparam int unsigned FIELD_W     = 11;
  localparam logic [31:0] BYPASS_KHZ  = 32'd19200;
  localparam logic [31:0] TOGGLE_KHZ  = 32'd624000;
  localparam logic [31:0] PRECHG_KHZ  = 32'd500000;
  localparam logic [7:0]  MBOX_OP     = 8'h17;
  localparam logic [31:0] NOTIFY_WORD = 32'h8000_0000;

  typedef enum logic [1:0] {DIV_1 = 2'd0, DIV_1P5 = 2'd1, DIV_2 = 2'd2, DIV_4 = 2'd3} div_code_e;
  typedef enum logic [1:0] {ERR_RATE = 2'd0, ERR_MBOX = 2'd1, ERR_TIMEOUT = 2'd2} err_cause_e;
  typedef enum logic [2:0] {
    S_IDLE, S_NOTIFY, S_OFF_WAIT, S_ON_START, S_ON_WAIT, S_WRITE, S_FINAL
  } seq_state_e;

  typedef struct packed {
    logic               ok;
    logic               bypass;
    logic [RATIO_W-1:0] ratio;
    div_code_e          div;
  } rate_cfg_t;

  function automatic rate_cfg_t mk_cfg(input logic ok, input logic byp,
                                       input logic [RATIO_W-1:0] r, input div_code_e d);
    rate_cfg_t c;
    c.ok = ok; c.bypass = byp; c.ratio = r; c.div = d;
    return c;
  endfunction

  function automatic rate_cfg_t rate_lookup(input logic [31:0] khz);
    case (khz)
      32'd19200:  return mk_cfg(1'b1, 1'b1, 8'd0,  DIV_1);
      32'd144000: return mk_cfg(1'b1, 1'b0, 8'd60, DIV_4);
      32'd288000: return mk_cfg(1'b1, 1'b0, 8'd60, DIV_2);
      32'd384000: return mk_cfg(1'b1, 1'b0, 8'd60, DIV_1P5);
      32'd576000: return mk_cfg(1'b1, 1'b0, 8'd60, DIV_1);
      32'd624000: return mk_cfg(1'b1, 1'b0, 8'd65, DIV_1);
      default:    return mk_cfg(1'b0, 1'b0, 8'd0,  DIV_1);
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] khz_to_field(input logic [31:0] khz);
    logic [31:0] t;
    t = (khz - 32'd1000) / 32'd500;
    return t[FIELD_W-1:0];
  endfunction

  function automatic logic [31:0] field_to_khz(input logic [FIELD_W-1:0] f);
    return {{(32-FIELD_W){1'b0}}, f} * 32'd500 + 32'd1000;
  endfunction

  function automatic logic [31:0] khz_to_mbox(input logic [31:0] khz);
    return (khz + 32'd24999) / 32'd25000;
  endfunction

  function automatic logic [31:0] ctl_assemble(input logic [31:0] prev, input div_code_e d,
                                               input logic [31:0] khz);
    logic [31:0] w;
    w = prev;
    w[23:22] = d;
    w[16] = (khz >= PRECHG_KHZ);
    w[FIELD_W-1:0] = khz_to_field(khz);
    return w;
  endfunction

endpackage

// File: rtl/dclk_rate_map.sv
module dclk_rate_map
  import dclk_pkg::*;
(
  input  logic [31:0] khz,
  output rate_cfg_t   cfg
);
  assign cfg = rate_lookup(khz);
endmodule

// File: rtl/dclk_us_timer.sv
module dclk_us_timer #(
  parameter int unsigned LIMIT_US = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT_US + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT_US);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == LIM);
endmodule

// File: rtl/dclk_rate_seq.sv
module dclk_rate_seq
  import dclk_pkg::*;
#(
  parameter int unsigned LOCK_LIMIT_US = 1000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_khz,
  output logic        busy,
  output logic        mbox_req,
  output logic [7:0]  mbox_cmd,
  output logic [31:0] mbox_data,
  input  logic        mbox_ack,
  input  logic        mbox_err,
  input  logic        us_tick,
  output logic        pll_en,
  output logic [7:0]  pll_ratio,
  input  logic        pll_lock,
  output logic [31:0] ctl_word,
  output logic [31:0] cur_khz,
  output logic        done,
  output logic        err,
  output logic [1:0]  err_cause
);

  seq_state_e  state;
  rate_cfg_t   req_cfg;
  rate_cfg_t   tgt_cfg;
  logic [31:0] tgt_khz;
  logic [31:0] ctl_khz;
  logic        need_toggle;
  logic        wait_run;
  logic        wait_expired;
  logic        mbox_ok;
  logic        mbox_bad;

  dclk_rate_map u_map (.khz(req_khz), .cfg(req_cfg));

  dclk_us_timer #(.LIMIT_US(LOCK_LIMIT_US)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .tick(us_tick), .expired(wait_expired)
  );

  // rate currently programmed in the control word, decoded from its field
  assign ctl_khz     = field_to_khz(ctl_word[FIELD_W-1:0]);
  assign need_toggle = tgt_cfg.bypass || (tgt_khz == TOGGLE_KHZ) || (ctl_khz == TOGGLE_KHZ);
  assign wait_run    = (state == S_OFF_WAIT) || (state == S_ON_WAIT);
  assign mbox_ok     = mbox_req && mbox_ack && !mbox_err;
  assign mbox_bad    = mbox_req && mbox_ack && mbox_err;
  assign busy        = (state != S_IDLE);
  assign mbox_cmd    = MBOX_OP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tgt_cfg   <= '0;
      tgt_khz   <= '0;
      mbox_req  <= 1'b0;
      mbox_data <= '0;
      pll_en    <= 1'b0;
      pll_ratio <= '0;
      ctl_word  <= '0;
      cur_khz   <= BYPASS_KHZ;
      done      <= 1'b0;
      err       <= 1'b0;
      err_cause <= ERR_RATE;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            if (req_cfg.ok) begin
              tgt_cfg   <= req_cfg;
              tgt_khz   <= req_khz;
              mbox_req  <= 1'b1;
              mbox_data <= NOTIFY_WORD;
              state     <= S_NOTIFY;
            end else begin
              err       <= 1'b1;
              err_cause <= ERR_RATE;
            end
          end
        end
        S_NOTIFY: begin
          if (mbox_ack) begin
            mbox_req <= 1'b0;
            if (mbox_bad) begin
              err       <= 1'b1;
              err_cause <= ERR_MBOX;
              state     <= S_IDLE;
            end else if (need_toggle) begin
              pll_en <= 1'b0;
              state  <= S_OFF_WAIT;
            end else begin
              state <= S_ON_START;
            end
          end
        end
        S_OFF_WAIT: begin
          if (!pll_lock) begin
            if (tgt_cfg.bypass) begin
              mbox_req  <= 1'b1;
              mbox_data <= khz_to_mbox(tgt_khz);
              state     <= S_FINAL;
            end else begin
              state <= S_ON_START;
            end
          end else if (wait_expired) begin
            err       <= 1'b1;
            err_cause <= ERR_TIMEOUT;
            state     <= S_IDLE;
          end
        end
        S_ON_START: begin
          pll_ratio <= tgt_cfg.ratio;
          pll_en    <= 1'b1;
          state     <= S_ON_WAIT;
        end
        S_ON_WAIT: begin
          if (pll_lock) begin
            state <= S_WRITE;
          end else if (wait_expired) begin
            err       <= 1'b1;
            err_cause <= ERR_TIMEOUT;
            state     <= S_IDLE;
          end
        end
        S_WRITE: begin
          ctl_word  <= ctl_assemble(ctl_word, tgt_cfg.div, tgt_khz);
          mbox_req  <= 1'b1;
          mbox_data <= khz_to_mbox(tgt_khz);
          state     <= S_FINAL;
        end
        S_FINAL: begin
          if (mbox_ack) begin
            mbox_req <= 1'b0;
            state    <= S_IDLE;
            if (mbox_ok) begin
              done    <= 1'b1;
              cur_khz <= tgt_khz;
            end else begin
              err       <= 1'b1;
              err_cause <= ERR_MBOX;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dclk_rate_seq_chk.sv
module dclk_rate_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mbox_req,
  input logic [7:0]  mbox_cmd,
  input logic [31:0] mbox_data,
  input logic        mbox_ack,
  input logic        pll_en,
  input logic [31:0] ctl_word,
  input logic [31:0] cur_khz,
  input logic        done,
  input logic        err
);

  // R10
  mbox_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_req && !mbox_ack |=> mbox_req && $stable(mbox_data));

  // R10
  mbox_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_req && mbox_ack |=> !mbox_req);

  // R4
  mbox_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mbox_req |-> mbox_cmd == 8'h17);

  // R9
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  // R1
  done_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pll_en == (cur_khz != 32'd19200));

  // R8
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_word != 32'd0) |-> ctl_word[16] == (ctl_word[10:0] >= 11'd998));

  // R6
  pll_fall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_en) |-> $past(busy));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mbox_req);

endmodule

bind dclk_rate_seq dclk_rate_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mbox_req(mbox_req), .mbox_cmd(mbox_cmd),
  .mbox_data(mbox_data), .mbox_ack(mbox_ack), .pll_en(pll_en), .ctl_word(ctl_word),
  .cur_khz(cur_khz), .done(done), .err(err)
);

// File: tb/dclk_rate_seq_test.sv
module dclk_rate_seq_test;

  localparam int LIM_US = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_khz = '0;
  logic        busy, mbox_req, pll_en, done, err;
  logic [7:0]  mbox_cmd, pll_ratio;
  logic [31:0] mbox_data, ctl_word, cur_khz;
  logic [1:0]  err_cause;
  logic        mbox_ack = 1'b0, mbox_err = 1'b0, us_tick = 1'b0, pll_lock = 1'b0;

  dclk_rate_seq #(.LOCK_LIMIT_US(LIM_US)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_khz(req_khz), .busy(busy),
    .mbox_req(mbox_req), .mbox_cmd(mbox_cmd), .mbox_data(mbox_data), .mbox_ack(mbox_ack),
    .mbox_err(mbox_err), .us_tick(us_tick), .pll_en(pll_en), .pll_ratio(pll_ratio),
    .pll_lock(pll_lock), .ctl_word(ctl_word), .cur_khz(cur_khz), .done(done), .err(err),
    .err_cause(err_cause)
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_errs = 0;
  int fail_stage = 0, mb_n = 0, lock_mode = 0;
  logic [31:0] mb_data [2];
  logic fell_seen = 1'b0, prev_en = 1'b0;
  int tick_cnt = 0, lock_cnt = 0;

  logic        ref_en = 1'b0;
  logic [7:0]  ref_ratio = '0;
  logic [31:0] ref_ctl = '0, ref_cur = 32'd19200;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit rate_ok(input logic [31:0] k);
    return k == 19200 || k == 144000 || k == 288000 || k == 384000 || k == 576000 || k == 624000;
  endfunction
  function automatic logic [31:0] exp_ctl(input logic [31:0] k);
    logic [1:0] d;
    d = (k == 144000) ? 2'd3 : (k == 288000) ? 2'd2 : (k == 384000) ? 2'd1 : 2'd0;
    return (32'(d) << 22) | ((k >= 500000) ? 32'h1_0000 : 32'h0) | (k / 500 - 2);
  endfunction

  // microsecond strobe every 4 cycles, PLL model
  always @(posedge clk) begin
    tick_cnt <= (tick_cnt == 3) ? 0 : tick_cnt + 1;
    us_tick  <= (tick_cnt == 3);
    if (pll_en && lock_cnt < 3) lock_cnt <= lock_cnt + 1;
    else if (!pll_en && lock_cnt > 0) lock_cnt <= lock_cnt - 1;
    if (lock_mode == 1) pll_lock <= 1'b0;
    else if (lock_mode == 2) pll_lock <= pll_lock | (lock_cnt == 3);
    else pll_lock <= (lock_cnt == 3);
  end

  always @(negedge clk) begin
    if (prev_en && !pll_en) fell_seen = 1'b1;
    prev_en = pll_en;
  end

  // power controller mailbox model
  initial begin
    forever begin
      @(negedge clk);
      if (mbox_req && rst_n) begin
        repeat (2) @(negedge clk);
        if (mb_n < 2) mb_data[mb_n] = mbox_data;
        mbox_err = (fail_stage == mb_n + 1);
        mbox_ack = 1'b1;
        mb_n++;
        @(negedge clk);
        mbox_ack = 1'b0;
        mbox_err = 1'b0;
      end
    end
  end

  task automatic run_req(input logic [31:0] k, input int fstage, input int lmode);
    bit tog, byp, exp_done;
    logic [1:0] exp_cause;
    int exp_mb;
    logic [31:0] old_cur;
    byp = (k == 32'd19200);
    tog = byp || k == 32'd624000 || ((ref_ctl[10:0] * 500 + 1000) == 624000);
    exp_done = 1'b0; exp_cause = 2'd0; exp_mb = 0; old_cur = ref_cur;
    if (!rate_ok(k)) begin
      exp_cause = 2'd0;
    end else if (fstage == 1) begin
      exp_cause = 2'd1; exp_mb = 1;
    end else if (lmode == 2 && tog && ref_en) begin
      exp_cause = 2'd2; exp_mb = 1; ref_en = 1'b0;
    end else if (lmode == 1 && !byp) begin
      exp_cause = 2'd2; exp_mb = 1; ref_en = 1'b1; ref_ratio = (k == 624000) ? 8'd65 : 8'd60;
    end else begin
      exp_mb = 2;
      if (byp) ref_en = 1'b0;
      else begin
        ref_en = 1'b1; ref_ratio = (k == 624000) ? 8'd65 : 8'd60; ref_ctl = exp_ctl(k);
      end
      if (fstage == 2) exp_cause = 2'd1;
      else begin exp_done = 1'b1; ref_cur = k; end
    end
    fail_stage = fstage; lock_mode = lmode; mb_n = 0;
    @(negedge clk);
    fell_seen = 1'b0;
    req_valid = 1'b1; req_khz = k;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000 && !(done || err); i++) @(negedge clk);
    chk(done == exp_done && err == !exp_done, exp_done ? "R9 done" : "R3/R4/R7 err",
        {30'b0, done, err}, {30'b0, exp_done, !exp_done});
    if (!exp_done) chk(err_cause == exp_cause, "R3/R4/R7 cause", 32'(err_cause), 32'(exp_cause));
    chk(cur_khz == ref_cur, exp_done ? "R9 cur_khz" : "R3 cur_khz unchanged", cur_khz, ref_cur);
    chk(pll_en == ref_en, "R1 pll_en", 32'(pll_en), 32'(ref_en));
    if (ref_en) chk(pll_ratio == ref_ratio, "R1 ratio", 32'(pll_ratio), 32'(ref_ratio));
    chk(ctl_word == ref_ctl, "R2/R5/R8 ctl_word", ctl_word, ref_ctl);
    chk(mb_n == exp_mb, "R4 mailbox count", 32'(mb_n), 32'(exp_mb));
    if (exp_mb >= 1) chk(mb_data[0] == 32'h8000_0000, "R4 notify data", mb_data[0], 32'h8000_0000);
    if (exp_mb == 2) chk(mb_data[1] == (k + 24999) / 25000, "R9 final data", mb_data[1], (k + 24999) / 25000);
    if (exp_mb == 2 || exp_cause == 2'd2)
      chk(fell_seen == (tog && (old_cur != 0) && fell_seen_expect(tog)), "R6 toggle",
          32'(fell_seen), 32'(tog && fell_seen_expect(tog)));
    lock_mode = 0; fail_stage = 0;
    repeat (10) @(negedge clk);
  endtask

  // PLL was on before this request (tracked before the request updates it)
  logic pre_en = 1'b0;
  function automatic bit fell_seen_expect(input bit tog);
    return tog && pre_en;
  endfunction

  task automatic go(input logic [31:0] k, input int fstage, input int lmode);
    pre_en = ref_en;
    run_req(k, fstage, lmode);
  endtask

  bit finished = 1'b0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_errs++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] rates [6];
    rates = '{32'd19200, 32'd144000, 32'd288000, 32'd384000, 32'd576000, 32'd624000};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(cur_khz == 32'd19200, "R11 cur_khz", cur_khz, 32'd19200);
    chk(!pll_en && ctl_word == 0 && !mbox_req && !done && !err && !busy, "R11 outputs",
        {26'b0, pll_en, mbox_req, done, err, busy, 1'b0}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    go(32'd624000, 0, 0);   // R1 R6 from reset
    go(32'd100000, 0, 0);   // R3 unsupported
    go(32'd288000, 1, 0);   // R4 notify failure
    go(32'd144000, 0, 0);   // R6 toggle away from 624
    go(32'd384000, 2, 0);   // R9 final failure
    go(32'd576000, 0, 0);   // R8 precharge set
    go(32'd19200, 0, 2);    // R7 unlock timeout
    go(32'd288000, 0, 1);   // R7 lock timeout
    go(32'd288000, 0, 0);
    go(32'd19200, 0, 0);    // R1 bypass
    go(32'd576000, 0, 0);
    for (int i = 0; i < 40; i++) begin
      int sel, fs;
      logic [31:0] k;
      sel = int'($urandom % 8);
      k = (sel < 6) ? rates[sel] : 32'd200000 + ($urandom % 400);
      fs = (($urandom % 6) == 0) ? int'(1 + $urandom % 2) : 0;
      go(k, fs, 0);
    end
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule